// File: doc/BRIEF.md
# Shared-Pool Packet Switch

This block switches single-word packets between NPORT input ports and NPORT output ports. No input port or output port has a private buffer. Every accepted packet is written into one storage array that all inputs share. Inside that array, each output port owns a logical FIFO. The FIFO is built as a linked list of slots, so its length grows and shrinks with the traffic to that output. A lightly loaded output therefore holds few slots, and a congested one may take the whole pool.

In each clock cycle, every input may offer one packet with a binary destination index, and every output may hand one packet downstream. Free slots are tracked in a bitmap. Inputs receive slots in ascending port order, so allocation is deterministic. An arriving packet that finds no free slot is discarded and counted. Because every output has its own queue, a stalled output never holds back traffic bound for other outputs.

Top module: `shmem_pkt_switch`

## Requirements
- R1: After synchronous reset, every `out_valid` bit is low and `drop_count` is zero.
- R2: An accepted packet from any input appears on the output whose index equals its `in_dest` field, where the field is the binary port number. Its data word is unchanged.
- R3: Each output delivers its packets in arrival order. Packets that arrive at the same output in the same cycle leave in ascending input-port order.
- R4: `out_valid[p]` is high exactly when output p's queue holds a packet. A packet accepted at a clock edge is presented from that edge onward, one cycle after it is offered.
- R5: A packet leaves output p only in a cycle where `out_valid[p]` and `out_ready[p]` are both high. While `out_ready[p]` is low, `out_valid[p]` and the data on that output stay unchanged.
- R6: One output queue alone may occupy all DEPTH slots of the pool.
- R7: In a cycle with F free slots at its start, the valid inputs with the lowest port numbers take the slots, up to F of them. Each remaining valid input is dropped, and `drop_count` rises by one for each dropped packet.
- R8: A slot released by a dequeue becomes free only for arrivals in the following cycle, not in the same cycle.
- R9: A stalled, non-empty output does not delay packets bound for other outputs.
- R10: All NPORT inputs can be accepted, and all NPORT outputs can deliver, in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NPORT | A packet is offered on each input whose bit is set |
| in_dest | input | NPORT*log2(NPORT) | Destination output index for each input, in binary |
| in_data | input | NPORT*DW | Packet word for each input |
| out_ready | input | NPORT | Downstream of each output can take a packet |
| out_valid | output | NPORT | Each output has a packet to present |
| out_data | output | NPORT*DW | Head packet of each output queue |
| drop_count | output | CNTW | Number of discarded arrivals (wraps) |

## Verification
The hardest situation to reach from the ports is a cycle that begins with the pool exactly full, in which a dequeue and a burst of arrivals coincide. This cycle separates same-cycle slot reuse from next-cycle reuse, and it also exposes the ascending-order rule for partial acceptance. The stimulus reaches it by stalling every output and loading one output from three inputs at a time until a single slot remains. It then offers four packets, and finally opens that output's ready in the same cycle as another full burst. A long randomized phase with independent ready patterns is compared every cycle against a queue-based model. That phase mixes same-destination bursts and empty-queue refills with simultaneous enqueue and dequeue.

// File: rtl/ssw_pkg.sv
// Package: default sizing shared by the switch top and its bench.
// Assumes DEPTH is a power of two and NPORT is at least 2.
package ssw_pkg;
    localparam int SSW_PORTS_DEF = 4;
    localparam int SSW_DEPTH_DEF = 16;
    localparam int SSW_DW_DEF    = 16;
    localparam int SSW_CNTW_DEF  = 16;
endpackage

// File: rtl/ssw_slot_alloc.sv
// Free-slot manager: a bitmap with one bit per storage slot (1 = free).
// Each cycle, requesting inputs are granted the lowest free slots in
// ascending input order. Slots released by dequeues are returned at the
// clock edge, so they can be granted again from the next cycle.
// Assumes released slots are never currently free.
module ssw_slot_alloc #(
    parameter int NPORT = 4,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      req,
    input  logic [NPORT-1:0]      rel_en,
    input  logic [NPORT*AW-1:0]   rel_slot,
    output logic [NPORT-1:0]      grant,
    output logic [NPORT*AW-1:0]   grant_slot,
    output logic [DEPTH-1:0]      free_map
);
    logic [DEPTH-1:0] free_q;
    logic [DEPTH-1:0] avail;
    logic [DEPTH-1:0] free_d;
    logic [AW-1:0]    pick [NPORT];

    // Purpose: hand out the lowest free slots, input 0 first.
    always_comb begin
        avail = free_q;
        for (int i = 0; i < NPORT; i++) begin
            grant[i] = 1'b0;
            pick[i]  = '0;
            if (req[i]) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (!grant[i] && avail[j]) begin
                        grant[i] = 1'b1;
                        pick[i]  = AW'(j);
                        avail[j] = 1'b0;
                    end
                end
            end
        end
    end

    // Purpose: next bitmap is the remaining free slots plus the released ones.
    always_comb begin
        free_d = avail;
        for (int o = 0; o < NPORT; o++)
            if (rel_en[o]) free_d[rel_slot[o*AW +: AW]] = 1'b1;
    end

    // Purpose: hold the bitmap; all slots are free after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= free_d;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_pack
        assign grant_slot[g*AW +: AW] = pick[g];
    end

    assign free_map = free_q;
endmodule

// File: rtl/ssw_vq_ctrl.sv
// Pointer control for one output's virtual queue (a linked list of slots).
// Holds the head, tail and length. It returns the next-pointer writes that
// chain this cycle's arrivals behind the tail, in ascending input order.
// Assumes wr_hit only flags granted inputs bound to this output, and that
// head_next is the stored successor of the current head.
module ssw_vq_ctrl #(
    parameter int NPORT = 4,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      wr_hit,
    input  logic [NPORT*AW-1:0]   wr_slot,
    input  logic                  deq,
    input  logic [AW-1:0]         head_next,
    output logic                  nonempty,
    output logic [AW-1:0]         head,
    output logic [NPORT-1:0]      link_we,
    output logic [NPORT*AW-1:0]   link_addr
);
    logic [CW-1:0] len_q, len_d, n_new;
    logic [AW-1:0] head_q, head_d, tail_q, tail_d;
    logic [AW-1:0] prev, first;
    logic          prev_ok, first_ok;

    // Purpose: chain the arrivals and work out the new pointers and length.
    always_comb begin
        prev     = tail_q;
        prev_ok  = (len_q != '0);
        first    = '0;
        first_ok = 1'b0;
        n_new    = '0;
        link_we  = '0;
        link_addr = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (wr_hit[i]) begin
                if (prev_ok) begin
                    link_we[i]             = 1'b1;
                    link_addr[i*AW +: AW]  = prev;
                end
                if (!first_ok) begin
                    first_ok = 1'b1;
                    first    = wr_slot[i*AW +: AW];
                end
                prev    = wr_slot[i*AW +: AW];
                prev_ok = 1'b1;
                n_new   = n_new + CW'(1);
            end
        end
        tail_d = (n_new != '0) ? prev : tail_q;
        if (len_q == '0 || (deq && len_q == CW'(1)))
            head_d = first_ok ? first : head_q;
        else if (deq)
            head_d = head_next;
        else
            head_d = head_q;
        len_d = len_q + n_new - CW'(deq);
    end

    // Purpose: register the queue state; the queue is empty after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            len_q  <= len_d;
            head_q <= head_d;
            tail_q <= tail_d;
        end
    end

    assign nonempty = (len_q != '0);
    assign head     = head_q;
endmodule

// File: rtl/ssw_store.sv
// Shared storage: a packet word and a next-pointer for every slot.
// Has NPORT write ports and NPORT read ports on each table. The tables
// carry no reset: a slot's contents are read only after it has been written.
// Assumes that no two write ports target the same entry in one cycle.
module ssw_store #(
    parameter int NPORT = 4,
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic [NPORT-1:0]      wr_en,
    input  logic [NPORT*AW-1:0]   wr_slot,
    input  logic [NPORT*DW-1:0]   wr_data,
    input  logic [NPORT-1:0]      lk_en,
    input  logic [NPORT*AW-1:0]   lk_addr,
    input  logic [NPORT*AW-1:0]   lk_val,
    input  logic [NPORT*AW-1:0]   rd_slot,
    output logic [NPORT*DW-1:0]   rd_data,
    output logic [NPORT*AW-1:0]   rd_next
);
    logic [DW-1:0] data_q [DEPTH];
    logic [AW-1:0] next_q [DEPTH];

    // Purpose: store arriving words and the links between queue entries.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NPORT; i++) begin
            if (wr_en[i]) data_q[wr_slot[i*AW +: AW]] <= wr_data[i*DW +: DW];
            if (lk_en[i]) next_q[lk_addr[i*AW +: AW]] <= lk_val[i*AW +: AW];
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_rd
        assign rd_data[g*DW +: DW] = data_q[rd_slot[g*AW +: AW]];
        assign rd_next[g*AW +: AW] = next_q[rd_slot[g*AW +: AW]];
    end
endmodule

// File: rtl/shmem_pkt_switch.sv
// Top of the shared-pool packet switch. Arrivals take slots from the shared
// pool and join the linked-list queue of their destination output. Each
// output presents its queue head and dequeues when its ready is high.
// Arrivals that find no free slot are dropped and counted.
// Assumes NPORT >= 2, DEPTH a power of two, and NPORT <= DEPTH.
module shmem_pkt_switch
    import ssw_pkg::*;
#(
    parameter int NPORT = SSW_PORTS_DEF,
    parameter int DEPTH = SSW_DEPTH_DEF,
    parameter int DW    = SSW_DW_DEF,
    parameter int CNTW  = SSW_CNTW_DEF,
    localparam int PW = $clog2(NPORT),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      in_valid,
    input  logic [NPORT*PW-1:0]   in_dest,
    input  logic [NPORT*DW-1:0]   in_data,
    input  logic [NPORT-1:0]      out_ready,
    output logic [NPORT-1:0]      out_valid,
    output logic [NPORT*DW-1:0]   out_data,
    output logic [CNTW-1:0]       drop_count
);
    logic [NPORT-1:0]      grant;
    logic [NPORT*AW-1:0]   grant_slot;
    logic [DEPTH-1:0]      free_map;
    logic [NPORT-1:0]      deq;
    logic [NPORT*AW-1:0]   head_flat;
    logic [NPORT*AW-1:0]   next_flat;
    logic [NPORT-1:0]      lk_en;
    logic [NPORT*AW-1:0]   lk_addr;
    logic [NPORT-1:0]      vq_lwe   [NPORT];
    logic [NPORT*AW-1:0]   vq_laddr [NPORT];
    logic [NPORT-1:0]      hit      [NPORT];
    logic [CNTW-1:0]       drop_q;

    assign deq = out_valid & out_ready;

    ssw_slot_alloc #(.NPORT(NPORT), .DEPTH(DEPTH)) u_alloc (
        .clk(clk), .rst_n(rst_n), .req(in_valid),
        .rel_en(deq), .rel_slot(head_flat),
        .grant(grant), .grant_slot(grant_slot), .free_map(free_map)
    );

    for (genvar o = 0; o < NPORT; o++) begin : g_vq
        // Purpose: flag the granted inputs that are bound to this output.
        always_comb begin
            for (int i = 0; i < NPORT; i++)
                hit[o][i] = grant[i] && (in_dest[i*PW +: PW] == PW'(o));
        end

        ssw_vq_ctrl #(.NPORT(NPORT), .DEPTH(DEPTH)) u_vq (
            .clk(clk), .rst_n(rst_n),
            .wr_hit(hit[o]), .wr_slot(grant_slot),
            .deq(deq[o]), .head_next(next_flat[o*AW +: AW]),
            .nonempty(out_valid[o]), .head(head_flat[o*AW +: AW]),
            .link_we(vq_lwe[o]), .link_addr(vq_laddr[o])
        );
    end

    // Purpose: merge the link writes (each input belongs to one output only).
    always_comb begin
        lk_en   = '0;
        lk_addr = '0;
        for (int o = 0; o < NPORT; o++) begin
            lk_en = lk_en | vq_lwe[o];
            for (int i = 0; i < NPORT; i++)
                if (vq_lwe[o][i]) lk_addr[i*AW +: AW] = vq_laddr[o][i*AW +: AW];
        end
    end

    ssw_store #(.NPORT(NPORT), .DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .wr_en(grant), .wr_slot(grant_slot), .wr_data(in_data),
        .lk_en(lk_en), .lk_addr(lk_addr), .lk_val(grant_slot),
        .rd_slot(head_flat), .rd_data(out_data), .rd_next(next_flat)
    );

    // Purpose: count the arrivals that found no slot.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= '0;
        else        drop_q <= drop_q + CNTW'($countones(in_valid & ~grant));
    end

    assign drop_count = drop_q;
endmodule

// File: rtl/ssw_checker.sv
// Checker for the shared-pool switch: reset state, output hold under
// back-pressure, and drop accounting against the free-slot bitmap.
module ssw_checker #(
    parameter int NPORT = 4,
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    parameter int CNTW  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NPORT-1:0]     in_valid,
    input logic [NPORT-1:0]     out_ready,
    input logic [NPORT-1:0]     out_valid,
    input logic [NPORT*DW-1:0]  out_data,
    input logic [CNTW-1:0]      drop_count,
    input logic [DEPTH-1:0]     free_map
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_valid == '0 && drop_count == '0));

    for (genvar p = 0; p < NPORT; p++) begin : g_hold
        assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && !out_ready[p]) |=>
            (out_valid[p] && $stable(out_data[p*DW +: DW])));
    end

    assert_drop_needs_shortage_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drop_count) |->
        ($past($countones(in_valid)) > $past($countones(free_map))));

    assert_no_drop_with_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(in_valid) <= $countones(free_map)) |=> $stable(drop_count));
endmodule

bind shmem_pkt_switch ssw_checker #(
    .NPORT(NPORT), .DEPTH(DEPTH), .DW(DW), .CNTW(CNTW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .drop_count(drop_count),
    .free_map(free_map)
);

// File: tb/shmem_pkt_switch_tb_top.sv
module shmem_pkt_switch_tb_top;
    localparam int NP = 4, DEP = 16, DW = 16, CNTW = 16, PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    in_valid, out_ready, out_valid;
    logic [NP*PW-1:0] in_dest;
    logic [NP*DW-1:0] in_data, out_data;
    logic [CNTW-1:0]  drop_count;

    int total = 0, bad = 0, seq = 1, model_drops = 0;
    int q [NP][$];

    always #2 clk = ~clk;

    shmem_pkt_switch #(.NPORT(NP), .DEPTH(DEP), .DW(DW), .CNTW(CNTW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        in_valid = '0; in_dest = '0; in_data = '0;
    endtask

    task automatic put(input int i, input int d);
        in_valid[i] = 1'b1;
        in_dest[i*PW +: PW] = PW'(d);
        in_data[i*DW +: DW] = DW'(seq);
        seq++;
    endtask

    // Compare against the model, advance the model, then move to the next negedge.
    task automatic step();
        int occ0, acc;
        for (int o = 0; o < NP; o++) begin
            check(out_valid[o] == (q[o].size() > 0), "R4 valid", int'(out_valid[o]), int'(q[o].size() > 0));
            if (q[o].size() > 0)
                check(int'(out_data[o*DW +: DW]) == q[o][0], "R2/R3 data", int'(out_data[o*DW +: DW]), q[o][0]);
        end
        check(int'(drop_count) == (model_drops % 65536), "R7 drops", int'(drop_count), model_drops % 65536);
        occ0 = 0;
        for (int o = 0; o < NP; o++) occ0 += q[o].size();
        for (int o = 0; o < NP; o++)
            if (out_ready[o] && q[o].size() > 0) void'(q[o].pop_front());
        acc = 0;
        for (int i = 0; i < NP; i++) begin
            if (in_valid[i]) begin
                if (occ0 + acc < DEP) begin
                    q[int'(in_dest[i*PW +: PW])].push_back(int'(in_data[i*DW +: DW]));
                    acc++;
                end else model_drops++;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base, s0, n0;
        clear_in();
        out_ready = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == '0, "R1 valid", int'(out_valid), 0);
        check(drop_count == '0, "R1 drops", int'(drop_count), 0);

        // R10: four arrivals to four outputs, then four departures at once.
        out_ready = '0;
        put(0, 3); put(1, 2); put(2, 1); put(3, 0);
        step(); clear_in();
        check($countones(out_valid) == NP, "R10 fill", $countones(out_valid), NP);
        out_ready = '1;
        step();
        check(out_valid == '0, "R10 drain", int'(out_valid), 0);

        // R3: same-cycle arrivals to one output leave in input order.
        out_ready = '0;
        s0 = seq;
        for (int i = 0; i < NP; i++) put(i, 1);
        step(); clear_in();
        check(int'(out_data[DW +: DW]) == s0, "R3 head", int'(out_data[DW +: DW]), s0);
        out_ready[1] = 1'b1;
        repeat (NP) step();
        check(out_valid[1] == 1'b0, "R3 empty", int'(out_valid[1]), 0);

        // R9: output 0 stalled while output 3 keeps flowing.
        out_ready = 4'b1110;
        put(0, 0); put(1, 0); put(2, 3);
        step(); clear_in();
        put(3, 3);
        step(); clear_in();
        step();
        check(out_valid[3] == 1'b0 && out_valid[0] == 1'b1, "R9 no blocking", int'(out_valid), 1);
        out_ready = '1;
        repeat (3) step();

        // R6/R7: one output absorbs the whole pool; partial acceptance in order.
        out_ready = '0;
        base = int'(drop_count);
        for (int c = 0; c < 5; c++) begin
            put(0, 0); put(1, 0); put(2, 0);
            step(); clear_in();
        end
        for (int i = 0; i < NP; i++) put(i, 0);
        step(); clear_in();
        check(int'(drop_count) - base == 3, "R7 partial", int'(drop_count) - base, 3);
        check(out_valid == 4'b0001, "R6 one queue", int'(out_valid), 1);

        // R8: a dequeue from a full pool frees nothing for the same cycle.
        out_ready[0] = 1'b1;
        for (int i = 0; i < NP; i++) put(i, 0);
        step(); clear_in();
        check(int'(drop_count) - base == 7, "R8 same cycle", int'(drop_count) - base, 7);
        out_ready[0] = 1'b0;
        put(2, 1);
        step(); clear_in();
        check(int'(drop_count) - base == 7, "R8 next cycle", int'(drop_count) - base, 7);
        check(out_valid[1] == 1'b1, "R8 reuse", int'(out_valid[1]), 1);

        out_ready = '1;
        n0 = 0;
        for (int c = 0; c < DEP + 2; c++) begin
            if (out_valid[0]) n0++;
            step();
        end
        check(n0 == DEP - 1, "R6 depth", n0, DEP - 1);

        // Randomized traffic with independent back-pressure.
        for (int c = 0; c < 3000; c++) begin
            clear_in();
            for (int i = 0; i < NP; i++)
                if ($urandom_range(9) < 6) put(i, int'($urandom_range(NP - 1)));
            for (int o = 0; o < NP; o++) out_ready[o] = ($urandom_range(1) == 1);
            step();
        end

        clear_in();
        out_ready = '1;
        repeat (DEP + 2) step();
        check(out_valid == '0, "R4 final empty", int'(out_valid), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule